// File: doc/BRIEF.md
# Configuration ROM CRC-8 Checker

This block validates a configuration ROM image held in 16-bit words. After a start request it reads the image through a simple synchronous read port, one address per cycle, and folds every word into an 8-bit CRC. It then compares the result with the check byte kept in the upper half of the image's final word.

Images come in two lengths. The short length is tried first. If its check byte does not match, the block reads the image again at the long length. A CRC failure is reported only when both lengths fail. When the block finishes, it pulses `done` and presents three results: whether the check passed, the word count it settled on, and the revision byte found in the lower half of that length's final word. These results stay put until the next accepted start.

The CRC uses the polynomial x^8 + x^7 + x^6 + x^4 + x^2 + 1 in bit-reversed form (constant 0xAB), shifting out the least significant bit first. The byte update is computed by logic, not looked up in a stored table.

Top module: `cfgrom_crc_check`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, `done`, `crc_ok`, `rd_en`, `size_words` and `revision` are all 0.
- R2: The CRC register is loaded with 0xFF at the start of each pass. Every word except the last is fed as its bits 7:0 and then its bits 15:8. Each byte is shifted in least significant bit first with the reversed constant 0xAB, so that the byte update applied to register values 0, 1, 2 and 3 gives 0x00, 0xF7, 0xB9 and 0x4E.
- R3: For the final word, only bits 7:0 are fed. The register is then inverted (XOR 0xFF), and the pass succeeds when the result equals bits 15:8 of that word.
- R4: If the short pass succeeds, `done` is high in the (SHORT_WORDS+2)th cycle after the accepting clock edge, with `crc_ok`=1 and `size_words`=SHORT_WORDS.
- R5: If the short pass fails, addresses 0 to LONG_WORDS-1 are read again, starting two cycles after the short pass's last address. `done` follows in cycle SHORT_WORDS+LONG_WORDS+3, with `size_words`=LONG_WORDS and `crc_ok` equal to the result of the long pass.
- R6: Reads are issued with `rd_en`=1 and ascending, gap-free addresses from 0 within a pass. `rd_data` is expected one cycle after the address. `done` never coincides with `rd_en`.
- R7: `done` is a single-cycle pulse. `revision` is bits 7:0 of word `size_words`-1. `crc_ok`, `size_words` and `revision` hold after `done` and are cleared to 0 when the next start is accepted.
- R8: A `start` that arrives while a check is in progress is ignored. It does not change the read sequence, the timing of `done` or the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a check (accepted only when idle) |
| rd_en | output | 1 | Read request to the ROM |
| rd_addr | output | $clog2(LONG_WORDS) | Word address of the read |
| rd_data | input | 16 | ROM word, valid one cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| crc_ok | output | 1 | Check byte matched at the selected size |
| size_words | output | $clog2(LONG_WORDS+1) | Selected image length in words |
| revision | output | 8 | Bits 7:0 of the final word of the selected image |

## Verification
The bench builds the block with its default sizes of 64 and 220 words, so every scenario uses full-length images. Three images exercise the three outcomes: one valid at 64 words, one corrupt at 64 but valid at 220, and one corrupt at both lengths. The reference model predicts `rd_en`, the address and `done` on every clock, which checks the exact retry latency and the re-read sequence. It also checks its own byte update against the first four table values, checks that results hold and are cleared across back-to-back runs, and injects a start mid-run.

// File: rtl/cfgrom_crc_pkg.sv
// Shared constants for the configuration ROM CRC checker.
// Assumes the CRC is 8 bits wide and processed least significant bit first.
package cfgrom_crc_pkg;
    localparam int          WORD_W     = 16;
    localparam int          CRC_W      = 8;
    localparam logic [7:0]  CRC_POLY_R = 8'hAB;  // bit-reversed 0xD5
    localparam logic [7:0]  CRC_INIT   = 8'hFF;
    localparam logic [7:0]  CRC_XOROUT = 8'hFF;
endpackage

// File: rtl/crc8_byte_step.sv
// Combinational one-byte CRC-8 update, least significant bit first.
// Assumes the reversed polynomial constant is given as POLY.
module crc8_byte_step #(
    parameter logic [7:0] POLY = 8'hAB
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);
    // Purpose: eight unrolled shift/conditional-XOR steps.
    always_comb begin
        logic [7:0] c;
        c = crc_in ^ data_in;
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
        end
        crc_out = c;
    end
endmodule

// File: rtl/cfgrom_word_acc.sv
// Word accumulator: folds a 16-bit word (low byte, then high byte) into the CRC.
// For the final word it folds only the low byte, inverts the result and compares
// it with the high byte. Assumes word_vld is held for one cycle per word.
module cfgrom_word_acc
    import cfgrom_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              word_vld,
    input  logic              word_last,
    input  logic [WORD_W-1:0] word,
    output logic              match
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] after_lo;
    logic [CRC_W-1:0] after_hi;

    crc8_byte_step #(.POLY(CRC_POLY_R)) u_lo (
        .crc_in (crc_q),
        .data_in(word[7:0]),
        .crc_out(after_lo)
    );

    crc8_byte_step #(.POLY(CRC_POLY_R)) u_hi (
        .crc_in (after_lo),
        .data_in(word[15:8]),
        .crc_out(after_hi)
    );

    // Purpose: final check byte compare on the last word.
    assign match = ((after_lo ^ CRC_XOROUT) == word[15:8]);

    // Purpose: CRC register, reloaded per pass and advanced per non-final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_INIT;
        end else if (clear) begin
            crc_q <= CRC_INIT;
        end else if (word_vld && !word_last) begin
            crc_q <= after_hi;
        end
    end
endmodule

// File: rtl/cfgrom_pass_ctrl.sv
// Pass controller: issues the reads for the short pass and, if that fails,
// the long pass. It tracks the returning data and signals completion.
// Assumes the read port returns data exactly one cycle after rd_en.
module cfgrom_pass_ctrl #(
    parameter int SHORT_WORDS = 64,
    parameter int LONG_WORDS  = 220,
    localparam int AW = $clog2(LONG_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          match,
    output logic          accept,
    output logic          clear,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          word_vld,
    output logic          word_last,
    output logic          finish,
    output logic          long_sel
);
    localparam logic [AW-1:0] SHORT_LAST = AW'(SHORT_WORDS - 1);
    localparam logic [AW-1:0] LONG_LAST  = AW'(LONG_WORDS - 1);

    logic          busy_q;
    logic          issuing_q;
    logic [AW-1:0] addr_q;
    logic          dv_q;
    logic          dlast_q;
    logic          long_q;
    logic [AW-1:0] limit;
    logic          retry;

    assign limit     = long_q ? LONG_LAST : SHORT_LAST;
    assign accept    = start && !busy_q;
    assign retry     = dv_q && dlast_q && !match && !long_q;
    assign finish    = dv_q && dlast_q && (match || long_q);
    assign clear     = accept || retry;
    assign rd_en     = issuing_q;
    assign rd_addr   = addr_q;
    assign word_vld  = dv_q;
    assign word_last = dlast_q;
    assign long_sel  = long_q;

    // Purpose: read-return tracking, one cycle behind the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q    <= 1'b0;
            dlast_q <= 1'b0;
        end else begin
            dv_q    <= issuing_q;
            dlast_q <= issuing_q && (addr_q == limit);
        end
    end

    // Purpose: pass sequencing (idle, short read, optional long re-read).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            issuing_q <= 1'b0;
            addr_q    <= '0;
            long_q    <= 1'b0;
        end else if (accept) begin
            busy_q    <= 1'b1;
            issuing_q <= 1'b1;
            addr_q    <= '0;
            long_q    <= 1'b0;
        end else if (issuing_q) begin
            if (addr_q == limit) begin
                issuing_q <= 1'b0;
            end else begin
                addr_q <= addr_q + AW'(1);
            end
        end else if (retry) begin
            long_q    <= 1'b1;
            issuing_q <= 1'b1;
            addr_q    <= '0;
        end else if (finish) begin
            busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgrom_crc_check.sv
// Top: configuration ROM CRC-8 checker with short/long image size fallback.
// Assumes a synchronous ROM read port with one-cycle latency.
module cfgrom_crc_check #(
    parameter int SHORT_WORDS = 64,
    parameter int LONG_WORDS  = 220,
    localparam int AW = $clog2(LONG_WORDS),
    localparam int SW = $clog2(LONG_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [15:0]   rd_data,
    output logic          done,
    output logic          crc_ok,
    output logic [SW-1:0] size_words,
    output logic [7:0]    revision
);
    logic accept, clear, word_vld, word_last, finish, long_sel, match;

    cfgrom_pass_ctrl #(
        .SHORT_WORDS(SHORT_WORDS),
        .LONG_WORDS (LONG_WORDS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .match    (match),
        .accept   (accept),
        .clear    (clear),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .word_vld (word_vld),
        .word_last(word_last),
        .finish   (finish),
        .long_sel (long_sel)
    );

    cfgrom_word_acc u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .word_vld (word_vld),
        .word_last(word_last),
        .word     (rd_data),
        .match    (match)
    );

    // Purpose: result registers, cleared on accept and loaded on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            crc_ok     <= 1'b0;
            size_words <= '0;
            revision   <= '0;
        end else begin
            done <= finish;
            if (accept) begin
                crc_ok     <= 1'b0;
                size_words <= '0;
                revision   <= '0;
            end else if (finish) begin
                crc_ok     <= match;
                size_words <= long_sel ? SW'(LONG_WORDS) : SW'(SHORT_WORDS);
                revision   <= rd_data[7:0];
            end
        end
    end
endmodule

// File: rtl/cfgrom_crc_check_chk.sv
// Checker for cfgrom_crc_check: port-level temporal properties.
// Assumes it is attached through the bind below.
module cfgrom_crc_check_chk #(
    parameter int SHORT_WORDS = 64,
    parameter int LONG_WORDS  = 220,
    localparam int AW = $clog2(LONG_WORDS),
    localparam int SW = $clog2(LONG_WORDS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          done,
    input logic          crc_ok,
    input logic [SW-1:0] size_words
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !rd_en && !crc_ok && size_words == '0));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && rd_addr != '0) |-> (rd_addr == $past(rd_addr) + AW'(1)));

    // R6
    no_done_while_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !done);

    // R5
    fail_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !crc_ok) |-> (size_words == SW'(LONG_WORDS)));

    // R4
    legal_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (size_words == SW'(SHORT_WORDS) || size_words == SW'(LONG_WORDS)));
endmodule

bind cfgrom_crc_check cfgrom_crc_check_chk #(
    .SHORT_WORDS(SHORT_WORDS),
    .LONG_WORDS (LONG_WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .done      (done),
    .crc_ok    (crc_ok),
    .size_words(size_words)
);

// File: tb/tb_cfgrom_crc_check.sv
`timescale 1ns/1ps
module tb_cfgrom_crc_check;
    localparam int S  = 64;
    localparam int L  = 220;
    localparam int AW = $clog2(L);
    localparam int SW = $clog2(L + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [15:0]   rd_data = '0;
    logic          done, crc_ok;
    logic [SW-1:0] size_words;
    logic [7:0]    revision;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] rom [L];

    always #4 clk = ~clk;

    cfgrom_crc_check dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .crc_ok(crc_ok),
        .size_words(size_words), .revision(revision)
    );

    // ROM model: one-cycle read latency
    always @(posedge clk) if (rd_en) rd_data <= rom[rd_addr];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference: bitwise, LSB-first CRC feed
    function automatic logic [7:0] feed(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int b = 0; b < 8; b++) begin
            logic fb = r[0] ^ d[b];
            r = r >> 1;
            if (fb) r = r ^ 8'hAB;
        end
        return r;
    endfunction

    function automatic logic [7:0] image_crc(input int n);
        logic [7:0] c = 8'hFF;
        for (int w = 0; w < n - 1; w++) begin
            c = feed(c, rom[w][7:0]);
            c = feed(c, rom[w][15:8]);
        end
        c = feed(c, rom[n-1][7:0]);
        return c ^ 8'hFF;
    endfunction

    task automatic fill(input logic [15:0] seed);
        for (int i = 0; i < L; i++) rom[i] = 16'(i * 16'h9E37) ^ seed;
    endtask

    // Run one check, comparing against the model on every clock.
    task automatic run(input bool_inject);
        bit ps, pl, retry, exp_ok;
        int dlat, sz;
        logic [7:0] rev;
        ps = (image_crc(S) == rom[S-1][15:8]);
        pl = (image_crc(L) == rom[L-1][15:8]);
        retry = !ps;
        exp_ok = ps || pl;
        sz = ps ? S : L;
        rev = rom[sz-1][7:0];
        dlat = retry ? (S + L + 3) : (S + 2);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 1; k <= dlat + 5; k++) begin
            bit er;
            int ea;
            er = (k >= 1 && k <= S) || (retry && k >= S + 2 && k <= S + L + 1);
            ea = (k <= S) ? k - 1 : k - S - 2;
            if (bool_inject && k == 5) start = 1'b1;   // R8 start while busy
            if (k == 6) start = 1'b0;
            chk(rd_en == er, "R6 rd_en", rd_en, er);
            if (er) chk(int'(rd_addr) == ea, retry && k > S ? "R5 re-read addr" : "R6 addr", rd_addr, ea);
            chk(done == (k == dlat), bool_inject ? "R8 done timing" : (retry ? "R5 done timing" : "R4 done timing"), done, k == dlat);
            if (k < dlat) chk(crc_ok == 1'b0, "R7 cleared on start", crc_ok, 0);
            if (k >= dlat) begin
                chk(crc_ok == exp_ok, retry ? "R5 crc_ok" : "R3 crc_ok", crc_ok, exp_ok);
                chk(int'(size_words) == sz, "R4 size", size_words, sz);
                chk(revision == rev, "R7 revision", revision, rev);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R2: model byte update against known table values
        chk(feed(8'h00, 8'h00) == 8'h00, "R2 table[0]", feed(8'h00, 8'h00), 8'h00);
        chk(feed(8'h01, 8'h00) == 8'hF7, "R2 table[1]", feed(8'h01, 8'h00), 8'hF7);
        chk(feed(8'h02, 8'h00) == 8'hB9, "R2 table[2]", feed(8'h02, 8'h00), 8'hB9);
        chk(feed(8'h03, 8'h00) == 8'h4E, "R2 table[3]", feed(8'h03, 8'h00), 8'h4E);
        fill(16'h1234);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !crc_ok && !rd_en, "R1 reset outputs", {done, crc_ok, rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(size_words == '0 && revision == '0, "R1 reset results", {size_words, revision}, 0);

        // R2/R3/R4: image valid at short size
        fill(16'h1234);
        rom[S-1][15:8] = image_crc(S);
        run(0);

        // R5: short corrupt, long valid
        fill(16'hA5C3);
        rom[S-1][15:8] = ~image_crc(S);
        rom[L-1][15:8] = image_crc(L);
        run(0);

        // R5: both corrupt
        fill(16'h0F0F);
        rom[S-1][15:8] = ~image_crc(S);
        rom[L-1][15:8] = ~image_crc(L);
        run(0);

        // R8: start injected during a retry run
        fill(16'h7E81);
        rom[S-1][15:8] = ~image_crc(S);
        rom[L-1][15:8] = image_crc(L);
        run(1);

        // R3: all-ones image, valid short
        for (int i = 0; i < L; i++) rom[i] = 16'hFFFF;
        rom[S-1][15:8] = image_crc(S);
        run(1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule